// File: doc/BRIEF.md
# Multi-Channel Latched Interrupt Bank

This block collects event pulses from eight identical framing channels and turns them into host-visible interrupts. Each channel has three sources: a one-second tick, timer 1 and timer 2. A one-cycle pulse on a source sets a sticky latched bit. A per-channel mask decides which latched bits count as interrupts. Reading a channel's latched-status or interrupt-status register returns its value and clears that channel's latched bits.

The host bus has a 12-bit address, single-cycle read and write strobes and 8-bit data. Address bits 11:8 pick a channel (0 to 7). The value 8 in that nibble sends one mask write to every channel at once. Two shared vector-mask registers sit at fixed addresses 0x902 and 0x903. One gates each channel and the other gates each source. Together they form a single active-high interrupt line for the whole bank.

Per-channel register offsets in address bits 7:0:
- 0x10: latched status. Read clears the channel's latched bits.
- 0x11: mask. Read/write.
- 0x12: interrupt status. Read clears the channel's latched bits.

Top module: `irq_bank`

## Requirements
- R1: A one-cycle pulse on `evt_i[3*c+s]` sets latched bit s of channel c at that clock edge. The bit stays set until a clearing read. Source encoding: s=0 is the one-second tick, s=1 is timer 1, s=2 is timer 2.
- R2: Bit s of channel c's interrupt status (offset 0x12) reads 1 exactly when latched bit s is 1 and mask bit s is 1. A mask bit of 1 means enabled. Bit 2 is timer 2, bit 1 is timer 1, bit 0 is the one-second source. Bits 7:3 read 0.
- R3: A read of offset 0x12 on channel c returns the interrupt status and clears all latched bits of channel c.
- R4: A read of offset 0x10 on channel c returns the latched bits in bits 2:0 and clears all latched bits of channel c.
- R5: If an event pulse arrives in the same cycle as a clearing read of its channel, the latched bit is set after that edge.
- R6: A write to offset 0x11 with address bits 11:8 equal to c (0 to 7) stores data bits 2:0 as channel c's mask. The stored mask is readable at the same address. No other channel's mask changes.
- R7: A write with address bits 11:8 equal to 8 and offset 0x11 stores the same mask in all eight channels.
- R8: Address 0x902 holds the 8-bit channel vector mask, where bit c enables channel c. Address 0x903 holds the source vector mask in bits 2:0, where bit s enables source s. Bits 7:3 of 0x903 read 0. Both are shared by all channels and are read/write.
- R9: `irq_o` is 1 exactly when some channel c has channel vector bit c set and some source s has latched bit s, mask bit s and source vector bit s all set. It follows register state with no added delay.
- R10: After reset, all latched bits, masks and vector masks are 0, `irq_o` is 0 and `rdata_o` is 0.
- R11: A read with address bits 11:8 equal to 8, or of any unmapped address, returns 0 and clears nothing. Writes to offsets 0x10 and 0x12 change nothing.
- R12: Read data appears on `rdata_o` in the cycle after the read strobe. `rdata_o` is 0 in every cycle that does not follow a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Host write strobe, one cycle per access |
| rd_i | input | 1 | Host read strobe, one cycle per access |
| addr_i | input | 12 | Host address: bits 11:8 select the channel, bits 7:0 the register |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Host read data, registered |
| evt_i | input | 24 | Event pulses, bit 3*c+s for channel c, source s |
| irq_o | output | 1 | Combined interrupt, active high |

## Verification
Events, mask writes, vector writes and clearing reads all take effect at the edge where they are sampled. `irq_o` reflects the new state right after that edge. Read data is registered once, so it appears one cycle after the strobe and drops back to zero after that. The bench drives each access for one cycle from the falling edge. It updates a behavioural model with the same stimulus and compares both outputs at the next falling edge. This places every comparison exactly one rising edge after its stimulus.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned DATA_W = 8;
  localparam logic [3:0] BCAST_SEL = 4'h8;
  localparam logic [7:0] LAT_OFS = 8'h10;
  localparam logic [7:0] MSK_OFS = 8'h11;
  localparam logic [7:0] INT_OFS = 8'h12;
  localparam logic [11:0] VCH_ADDR = 12'h902;
  localparam logic [11:0] VSRC_ADDR = 12'h903;

  typedef enum logic [2:0] {
    RS_NONE, RS_LAT, RS_MSK, RS_INT, RS_VCH, RS_VSRC
  } rsel_e;
endpackage

// File: rtl/irq_bank_dec.sv
module irq_bank_dec
  import irq_bank_pkg::*;
#(
  parameter int unsigned NCH = 8,
  localparam int unsigned CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                  wr_i,
  input  logic                  rd_i,
  input  logic [ADDR_W-1:0]     addr_i,
  output logic [NCH-1:0]        msk_we_o,
  output logic [NCH-1:0]        clr_o,
  output logic                  vch_we_o,
  output logic                  vsrc_we_o,
  output rsel_e                 rsel_o,
  output logic [CW-1:0]         rch_o
);
  logic [3:0] sel;
  logic [7:0] ofs;
  logic       ch_ok;

  assign sel   = addr_i[11:8];
  assign ofs   = addr_i[7:0];
  assign ch_ok = int'(sel) < int'(NCH);
  assign rch_o = sel[CW-1:0];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic hit;
    assign hit         = (sel == 4'(c));
    assign msk_we_o[c] = wr_i && (ofs == MSK_OFS) && (hit || sel == BCAST_SEL);
    assign clr_o[c]    = rd_i && hit && (ofs == LAT_OFS || ofs == INT_OFS);
  end

  assign vch_we_o  = wr_i && (addr_i == VCH_ADDR);
  assign vsrc_we_o = wr_i && (addr_i == VSRC_ADDR);

  always_comb begin
    rsel_o = RS_NONE;
    if (rd_i) begin
      if (ch_ok) begin
        unique case (ofs)
          LAT_OFS: rsel_o = RS_LAT;
          MSK_OFS: rsel_o = RS_MSK;
          INT_OFS: rsel_o = RS_INT;
          default: rsel_o = RS_NONE;
        endcase
      end else if (addr_i == VCH_ADDR) begin
        rsel_o = RS_VCH;
      end else if (addr_i == VSRC_ADDR) begin
        rsel_o = RS_VSRC;
      end
    end
  end
endmodule

// File: rtl/irq_bank_chan.sv
module irq_bank_chan #(
  parameter int unsigned NSRC = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] evt_i,
  input  logic            clr_i,
  input  logic            msk_we_i,
  input  logic [NSRC-1:0] msk_d_i,
  output logic [NSRC-1:0] lat_o,
  output logic [NSRC-1:0] msk_o,
  output logic [NSRC-1:0] int_o
);
  logic [NSRC-1:0] lat_q, msk_q;

  // new event wins over a clearing read in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lat_q <= '0;
    else         lat_q <= (clr_i ? '0 : lat_q) | evt_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       msk_q <= '0;
    else if (msk_we_i) msk_q <= msk_d_i;
  end

  assign lat_o = lat_q;
  assign msk_o = msk_q;
  assign int_o = lat_q & msk_q;
endmodule

// File: rtl/irq_bank.sv
module irq_bank
  import irq_bank_pkg::*;
#(
  parameter int unsigned NCH  = 8,
  parameter int unsigned NSRC = 3,
  localparam int unsigned CW  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int unsigned EW  = NCH * NSRC
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [EW-1:0]     evt_i,
  output logic              irq_o
);
  logic [NCH-1:0]  msk_we, clr;
  logic            vch_we, vsrc_we;
  rsel_e           rsel;
  logic [CW-1:0]   rch;
  logic [NSRC-1:0] lat [NCH];
  logic [NSRC-1:0] msk [NCH];
  logic [NSRC-1:0] intr[NCH];
  logic [EW-1:0]   lat_all;
  logic [NCH-1:0]  vec_ch_q;
  logic [NSRC-1:0] vec_src_q;
  logic [DATA_W-1:0] rd_val;

  irq_bank_dec #(.NCH(NCH)) u_dec (
    .wr_i(wr_i), .rd_i(rd_i), .addr_i(addr_i),
    .msk_we_o(msk_we), .clr_o(clr), .vch_we_o(vch_we), .vsrc_we_o(vsrc_we),
    .rsel_o(rsel), .rch_o(rch)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    irq_bank_chan #(.NSRC(NSRC)) u_chan (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .evt_i(evt_i[c*NSRC +: NSRC]),
      .clr_i(clr[c]), .msk_we_i(msk_we[c]), .msk_d_i(wdata_i[NSRC-1:0]),
      .lat_o(lat[c]), .msk_o(msk[c]), .int_o(intr[c])
    );
    assign lat_all[c*NSRC +: NSRC] = lat[c];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_ch_q  <= '0;
      vec_src_q <= '0;
    end else begin
      if (vch_we)  vec_ch_q  <= wdata_i[NCH-1:0];
      if (vsrc_we) vec_src_q <= wdata_i[NSRC-1:0];
    end
  end

  always_comb begin
    rd_val = '0;
    unique case (rsel)
      RS_LAT:  rd_val = DATA_W'(lat[rch]);
      RS_MSK:  rd_val = DATA_W'(msk[rch]);
      RS_INT:  rd_val = DATA_W'(intr[rch]);
      RS_VCH:  rd_val = DATA_W'(vec_ch_q);
      RS_VSRC: rd_val = DATA_W'(vec_src_q);
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= rd_val;
  end

  always_comb begin
    irq_o = 1'b0;
    for (int c = 0; c < NCH; c++)
      irq_o = irq_o | (vec_ch_q[c] & (|(intr[c] & vec_src_q)));
  end
endmodule

// File: rtl/irq_bank_chk.sv
module irq_bank_chk
  import irq_bank_pkg::*;
#(
  parameter int unsigned NCH  = 8,
  parameter int unsigned NSRC = 3,
  localparam int unsigned EW  = NCH * NSRC
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [EW-1:0]     evt_i,
  input logic              irq_o,
  input logic [EW-1:0]     lat_all,
  input logic [NCH-1:0]    vec_ch_q,
  input logic [NSRC-1:0]   vec_src_q
);
  assert_evt_latches_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((lat_all & $past(evt_i)) == $past(evt_i)));

  assert_no_spurious_set_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lat_all & ~$past(lat_all) & ~$past(evt_i)) == '0);

  assert_bcast_read_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i[11:8] == BCAST_SEL) |=> (rdata_o == '0));

  assert_idle_rdata_zero_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> (rdata_o == '0));

  assert_irq_needs_vec_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((vec_ch_q != '0) && (vec_src_q != '0)));

  for (genvar c = 0; c < NCH; c++) begin : g_clr
    assert_read_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_i && addr_i[11:8] == 4'(c) && (addr_i[7:0] == LAT_OFS || addr_i[7:0] == INT_OFS)
       && evt_i[c*NSRC +: NSRC] == '0) |=> (lat_all[c*NSRC +: NSRC] == '0));
  end
endmodule

bind irq_bank irq_bank_chk #(.NCH(NCH), .NSRC(NSRC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rd_i(rd_i), .addr_i(addr_i),
  .rdata_o(rdata_o), .evt_i(evt_i), .irq_o(irq_o),
  .lat_all(lat_all), .vec_ch_q(vec_ch_q), .vec_src_q(vec_src_q)
);

// File: tb/irq_bank_test.sv
module irq_bank_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [11:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [23:0] evt = '0;
  logic        irq;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [2:0] m_lat [8];
  logic [2:0] m_msk [8];
  logic [7:0] m_vch;
  logic [2:0] m_vsrc;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_bank uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .evt_i(evt), .irq_o(irq)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic model_irq();
    logic r = 1'b0;
    for (int c = 0; c < 8; c++)
      if (m_vch[c] && ((m_lat[c] & m_msk[c] & m_vsrc) != 0)) r = 1'b1;
    return r;
  endfunction

  // one bus/event cycle: drive at negedge, compare at next negedge
  task automatic step(input logic w, input logic r, input logic [11:0] a,
                      input logic [7:0] d, input logic [23:0] e, input string tag);
    logic [7:0] exp_rd = 8'h00;
    int y = int'(a[11:8]);
    logic [7:0] o = a[7:0];
    if (r) begin
      if (y < 8) begin
        if (o == 8'h10) exp_rd = {5'b0, m_lat[y]};
        else if (o == 8'h11) exp_rd = {5'b0, m_msk[y]};
        else if (o == 8'h12) exp_rd = {5'b0, m_lat[y] & m_msk[y]};
      end else if (a == 12'h902) exp_rd = m_vch;
      else if (a == 12'h903) exp_rd = {5'b0, m_vsrc};
    end
    for (int c = 0; c < 8; c++) begin
      logic [2:0] l = m_lat[c];
      if (r && y == c && (o == 8'h10 || o == 8'h12)) l = '0;
      m_lat[c] = l | e[c*3 +: 3];
      if (w && o == 8'h11 && (y == c || y == 8)) m_msk[c] = d[2:0];
    end
    if (w && a == 12'h902) m_vch = d;
    if (w && a == 12'h903) m_vsrc = d[2:0];
    wr = w; rd = r; addr = a; wdata = d; evt = e;
    @(negedge clk);
    wr = 1'b0; rd = 1'b0; evt = '0;
    check(tag, "rdata", int'(rdata), int'(exp_rd));
    check(tag, "irq", int'(irq), int'(model_irq()));
  endtask

  task automatic idle(input string tag);
    step(1'b0, 1'b0, 12'h000, 8'h00, 24'h0, tag);
  endtask
  task automatic hwr(input logic [11:0] a, input logic [7:0] d, input string tag);
    step(1'b1, 1'b0, a, d, 24'h0, tag);
  endtask
  task automatic hrd(input logic [11:0] a, input string tag);
    step(1'b0, 1'b1, a, 8'h00, 24'h0, tag);
  endtask
  task automatic ev(input logic [23:0] e, input string tag);
    step(1'b0, 1'b0, 12'h000, 8'h00, e, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    for (int c = 0; c < 8; c++) begin m_lat[c] = '0; m_msk[c] = '0; end
    m_vch = '0; m_vsrc = '0;
    repeat (3) @(negedge clk);
    check("R10", "rdata in reset", int'(rdata), 0);
    check("R10", "irq in reset", int'(irq), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int c = 0; c < 8; c++) hrd({4'(c), 8'h11}, "R10");
    hrd(12'h902, "R10"); hrd(12'h903, "R10");
    idle("R12");

    // R1 / R4: latch, hold, read-clear
    ev(24'h1 << 10, "R1");           // ch3 timer 1
    idle("R1"); idle("R1");
    hrd(12'h310, "R4"); idle("R12");
    hrd(12'h310, "R4");

    // R6: per-channel mask, neighbours untouched
    hwr(12'h211, 8'hFD, "R6");
    hrd(12'h211, "R6"); hrd(12'h111, "R6"); hrd(12'h311, "R6");

    // R2 / R3: interrupt status masking and clear
    ev(24'h7 << 6, "R2");
    hrd(12'h212, "R3");
    hrd(12'h210, "R3");
    ev(24'h2 << 6, "R2");
    hrd(12'h212, "R2");

    // R11: writes to read-only offsets, broadcast read, unmapped read
    ev(24'h1 << 15, "R11");          // ch5 one-second
    hwr(12'h510, 8'h00, "R11"); hwr(12'h512, 8'h00, "R11");
    hrd(12'h810, "R11"); hrd(12'h812, "R11"); hrd(12'h555, "R11"); hrd(12'hA02, "R11");
    hrd(12'h510, "R11");

    // R7: broadcast mask write
    hwr(12'h811, 8'h06, "R7");
    for (int c = 0; c < 8; c++) hrd({4'(c), 8'h11}, "R7");

    // R8: shared vector masks
    hwr(12'h902, 8'hA5, "R8"); hwr(12'h903, 8'hFF, "R8");
    hrd(12'h902, "R8"); hrd(12'h903, "R8");

    // R9: combined interrupt
    hwr(12'h811, 8'h07, "R9");
    ev(24'h1 << 3, "R9");            // ch1 not in vector mask
    idle("R9");
    ev(24'h1 << 0, "R9");            // ch0 enabled
    hrd(12'h012, "R9");
    hwr(12'h903, 8'h06, "R9");
    ev(24'h1 << 0, "R9");            // source 0 gated off
    ev(24'h4 << 0, "R9");            // timer 2 passes
    hwr(12'h902, 8'h00, "R9");
    hwr(12'h902, 8'h01, "R9");
    hrd(12'h010, "R9"); hrd(12'h110, "R9");

    // R5: event coincides with clearing read
    ev(24'h3 << 21, "R5");           // ch7
    step(1'b0, 1'b1, 12'h710, 8'h00, 24'h4 << 21, "R5");
    hrd(12'h710, "R5"); hrd(12'h710, "R5");
    step(1'b0, 1'b1, 12'h712, 8'h00, 24'h1 << 21, "R5");
    hrd(12'h710, "R5");

    // mixed traffic against the model
    for (int i = 0; i < 400; i++) begin
      logic [11:0] a;
      int k = int'($urandom_range(0, 9));
      logic [3:0] yy = 4'($urandom_range(0, 8));
      logic [7:0] oo = 8'h10 + 8'($urandom_range(0, 3));
      a = {yy, oo};
      if (k == 8) a = 12'h902;
      if (k == 9) a = 12'h903;
      case ($urandom_range(0, 2))
        0: step(1'b1, 1'b0, a, 8'($urandom), 24'($urandom) & 24'($urandom), "R9");
        1: step(1'b0, 1'b1, a, 8'h00, 24'($urandom) & 24'($urandom), "R12");
        default: step(1'b0, 1'b0, a, 8'h00, 24'($urandom) & 24'($urandom), "R1");
      endcase
    end
    idle("R12");
    finish_run();
  end
endmodule